// File: doc/BRIEF.md
# Pulse-Fed Handshake Output Buffer

This block lives in one clock domain. A producer announces each data word with a single-cycle strobe, and the block keeps the word for a consumer that takes it through a valid/ready handshake. The block has no ready signal on the input side. Instead it sends back a one-cycle "slot free" pulse, and the producer counts these pulses as credits. After a clear the producer may send as many words as the buffer can hold. After that it sends one word for each pulse it receives.

A parameter sets the storage size: a single-slot half buffer (capacity 1), a two-slot skid buffer (capacity 2), or a queue of `DEPTH` slots. With `CIRCULAR` set, the storage accepts every strobe. When it is full it discards its oldest word to make room, and it returns a pulse for every accepted word, so the producer is never held back. A synchronous `clear` empties the storage.

Control is an occupancy state machine with three states: `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`. Its transitions are:
- fill: `OCC_EMPTY` to `OCC_PARTIAL`, or straight to `OCC_FULL` when the capacity is 1.
- top-up: `OCC_PARTIAL` to `OCC_FULL`, when the last free slot is written with no read.
- drain: `OCC_PARTIAL` to `OCC_EMPTY`, when the last word is read with no write.
- release: `OCC_FULL` to `OCC_PARTIAL`, or to `OCC_EMPTY` when the capacity is 1, on a read with no write.
- swap: `OCC_FULL` to `OCC_FULL`, on a write and a read in the same cycle.
- overwrite: `OCC_FULL` to `OCC_FULL`, in circular mode only, on a write with no read.
- clear: from any state to `OCC_EMPTY`.

Top module: `pulse_stream_buffer`

## Requirements
- R1: If `clear` is high at a clock edge, then after that edge `out_valid` and `slot_free` are both 0 and the storage is empty. A slot-free pulse that was pending is suppressed.
- R2: The word is taken from `in_data` at the edge where `in_strobe` is high. Changes to `in_data` in later cycles do not affect it.
- R3: With `KIND` = half, at most one word is held. In non-circular mode a strobe that arrives while the word is still held, with no handshake in that cycle, is discarded.
- R4: With `KIND` = skid, a second word is accepted while the first waits downstream. A third word is discarded until a handshake frees a slot.
- R5: With `KIND` = FIFO, at most `DEPTH` words are held.
- R6: In non-circular mode, `slot_free` is high for exactly one cycle, in the cycle after each completed output handshake (`out_valid && out_ready`), and at no other time.
- R7: In circular mode, `slot_free` is high in the cycle after each `in_strobe`, and at no other time.
- R8: In non-circular mode, if `out_valid` is high and `out_ready` is low, then `out_valid` stays high and `out_data` is unchanged in the next cycle.
- R9: If the storage is full and a strobe and a handshake happen in the same cycle, the new word is accepted and the storage stays full.
- R10: In circular mode, a strobe into full storage with no handshake drops the oldest word and appends the new one. No word is ever output twice.
- R11: In non-circular mode, a strobe into full storage with no handshake changes neither the stored words nor their order.
- R12: Words leave in the order they arrived, leaving out any word that was discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear |
| in_strobe | input | 1 | Single-cycle strobe announcing a word on `in_data` |
| in_data | input | WIDTH | Word offered by the producer |
| slot_free | output | 1 | One-cycle pulse that grants the producer one more word |
| out_valid | output | 1 | A word is presented downstream |
| out_ready | input | 1 | The consumer takes the word presented |
| out_data | output | WIDTH | Oldest stored word |

## Verification
The hardest case to reach is full storage that receives a strobe and a handshake in the same cycle, because a producer that obeys the credits never sends into full storage. The bench ignores the credits on purpose. It fills every instance with the consumer stalled, then raises the strobe and `out_ready` together for several cycles. After that it keeps strobing into full storage with the consumer stalled, which exercises both the discard path and the overwrite path. A reference queue per instance, compared every cycle, tracks which words must still come out.

// File: rtl/pbuf_pkg.sv
`timescale 1ns/1ps
package pbuf_pkg;
    typedef enum logic [1:0] {
        BUF_HALF = 2'd0,
        BUF_SKID = 2'd1,
        BUF_FIFO = 2'd2
    } buf_kind_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;
endpackage

// File: rtl/pbuf_ring.sv
`timescale 1ns/1ps
module pbuf_ring #(
    parameter int WIDTH = 8,
    parameter int CAP   = 4
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_adv,
    output logic [WIDTH-1:0] rd_data
);
    generate
        if (CAP == 1) begin : g_single
            logic [WIDTH-1:0] slot_q;
            logic             unused_ctl;
            assign unused_ctl = clear ^ rd_adv;
            always_ff @(posedge clk) begin
                if (wr_en) slot_q <= wr_data;
            end
            assign rd_data = slot_q;
        end else begin : g_ring
            localparam int PW = $clog2(CAP);
            localparam logic [PW-1:0] LAST = PW'(CAP - 1);
            logic [WIDTH-1:0] mem [CAP];
            logic [PW-1:0]    wr_ptr, rd_ptr;

            function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
                return (p == LAST) ? '0 : p + 1'b1;
            endfunction

            always_ff @(posedge clk) begin
                if (clear) begin
                    wr_ptr <= '0;
                    rd_ptr <= '0;
                end else begin
                    if (wr_en) begin
                        mem[wr_ptr] <= wr_data;
                        wr_ptr      <= bump(wr_ptr);
                    end
                    if (rd_adv) rd_ptr <= bump(rd_ptr);
                end
            end
            assign rd_data = mem[rd_ptr];
        end
    endgenerate
endmodule

// File: rtl/pbuf_occupancy_fsm.sv
`timescale 1ns/1ps
module pbuf_occupancy_fsm
    import pbuf_pkg::*;
#(
    parameter int CAP      = 4,
    parameter bit CIRCULAR = 1'b0
) (
    input  logic clk,
    input  logic clear,
    input  logic push_req,
    input  logic pop_req,
    output logic has_word,
    output logic wr_en,
    output logic rd_adv,
    output logic pop
);
    localparam int CW = $clog2(CAP + 1);
    localparam logic [CW-1:0] LAST = CW'(CAP - 1);
    localparam logic [CW-1:0] CAPV = CW'(CAP);

    occ_state_e    state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic          is_full, drop;
    logic          armed = 1'b0;

    always_ff @(posedge clk) begin
        if (clear) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
            armed   <= 1'b1;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        has_word = (state_q != OCC_EMPTY);
        is_full  = (state_q == OCC_FULL);
        pop      = has_word && pop_req;
        if (CIRCULAR) begin
            wr_en = push_req;
            drop  = push_req && is_full && !pop;
        end else begin
            wr_en = push_req && (!is_full || pop);
            drop  = 1'b0;
        end
        rd_adv = pop || drop;
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q + CW'(wr_en) - CW'(rd_adv);
        unique case (state_q)
            OCC_EMPTY: begin
                if (wr_en) state_d = (CAP == 1) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (wr_en && !rd_adv && count_q == LAST)       state_d = OCC_FULL;
                else if (rd_adv && !wr_en && count_q == 1)     state_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (rd_adv && !wr_en) state_d = (CAP == 1) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: begin
                state_d = OCC_EMPTY;
                count_d = '0;
            end
        endcase
    end

    // R3 R4 R5: occupancy never exceeds the chosen capacity
    p_capacity_r5: assert property (@(posedge clk) disable iff (clear || !armed)
        count_q <= CAPV);

    // R9: a simultaneous write and read on a full store keeps it full
    p_full_swap_r9: assert property (@(posedge clk) disable iff (clear || !armed)
        (is_full && push_req && pop) |=> (state_q == OCC_FULL && $stable(count_q)));

    generate
        if (CIRCULAR) begin : g_circ_chk
            // R10: overwrite keeps the store full
            p_drop_r10: assert property (@(posedge clk) disable iff (clear || !armed)
                (is_full && push_req && !pop) |=> (state_q == OCC_FULL));
        end else begin : g_block_chk
            // R11: a strobe into a full store without a read is refused
            p_no_accept_r11: assert property (@(posedge clk) disable iff (clear || !armed)
                (is_full && push_req && !pop) |=> (state_q == OCC_FULL && $stable(count_q)));
        end
    endgenerate
endmodule

// File: rtl/pbuf_credit.sv
`timescale 1ns/1ps
module pbuf_credit #(
    parameter bit CIRCULAR = 1'b0
) (
    input  logic clk,
    input  logic clear,
    input  logic push_req,
    input  logic pop,
    output logic pulse
);
    logic source;
    generate
        if (CIRCULAR) begin : g_per_push
            logic unused_pop;
            assign unused_pop = pop;
            assign source = push_req;
        end else begin : g_per_pop
            logic unused_push;
            assign unused_push = push_req;
            assign source = pop;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clear) pulse <= 1'b0;
        else       pulse <= source;
    end
endmodule

// File: rtl/pulse_stream_buffer.sv
`timescale 1ns/1ps
module pulse_stream_buffer
    import pbuf_pkg::*;
#(
    parameter int        WIDTH    = 8,
    parameter buf_kind_e KIND     = BUF_FIFO,
    parameter int        DEPTH    = 4,
    parameter bit        CIRCULAR = 1'b0
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             in_strobe,
    input  logic [WIDTH-1:0] in_data,
    output logic             slot_free,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    localparam int CAP = (KIND == BUF_HALF) ? 1 : (KIND == BUF_SKID) ? 2 : DEPTH;

    logic wr_en, rd_adv, pop;
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (clear) armed <= 1'b1;
    end

    pbuf_occupancy_fsm #(.CAP(CAP), .CIRCULAR(CIRCULAR)) u_fsm (
        .clk      (clk),
        .clear    (clear),
        .push_req (in_strobe),
        .pop_req  (out_ready),
        .has_word (out_valid),
        .wr_en    (wr_en),
        .rd_adv   (rd_adv),
        .pop      (pop)
    );

    pbuf_ring #(.WIDTH(WIDTH), .CAP(CAP)) u_ring (
        .clk     (clk),
        .clear   (clear),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .rd_adv  (rd_adv),
        .rd_data (out_data)
    );

    pbuf_credit #(.CIRCULAR(CIRCULAR)) u_credit (
        .clk      (clk),
        .clear    (clear),
        .push_req (in_strobe),
        .pop      (pop),
        .pulse    (slot_free)
    );

    // R1: clear empties the store and cancels a pending pulse
    p_clear_r1: assert property (@(posedge clk)
        clear |=> (!out_valid && !slot_free));

    generate
        if (CIRCULAR) begin : g_circ_chk
            // R7: one pulse after every strobe
            p_credit_r7: assert property (@(posedge clk) disable iff (clear || !armed)
                (in_strobe && !clear) |=> slot_free);
            p_credit_only_r7: assert property (@(posedge clk) disable iff (clear || !armed)
                slot_free |-> $past(in_strobe));
        end else begin : g_block_chk
            // R6: one pulse after every handshake
            p_credit_r6: assert property (@(posedge clk) disable iff (clear || !armed)
                (out_valid && out_ready && !clear) |=> slot_free);
            p_credit_only_r6: assert property (@(posedge clk) disable iff (clear || !armed)
                slot_free |-> $past(out_valid && out_ready));
            // R8: a stalled word stays in place
            p_hold_r8: assert property (@(posedge clk) disable iff (clear || !armed)
                (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
        end
    endgenerate
endmodule

// File: tb/pulse_stream_buffer_test.sv
`timescale 1ns/1ps
module pulse_stream_buffer_test;
    import pbuf_pkg::*;
    localparam int W = 8;
    localparam int N = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         clear = 1'b1;
    logic [W-1:0] din   = '0;
    logic [N-1:0] strobe = '0, rdy = '0;
    logic [N-1:0] ov, sf;
    logic [W-1:0] od [N];

    // instance 0: FIFO, 1: half, 2: skid, 3: circular FIFO
    int caps [N]  = '{4, 1, 2, 4};
    bit circs [N] = '{1'b0, 1'b0, 1'b0, 1'b1};

    logic [W-1:0] mq [N][$];
    bit           exp_sf [N];
    string        tag = "R1";
    int checks = 0, errors = 0;

    pulse_stream_buffer #(.WIDTH(W), .KIND(BUF_FIFO), .DEPTH(4), .CIRCULAR(1'b0)) uut (
        .clk(clk), .clear(clear), .in_strobe(strobe[0]), .in_data(din), .slot_free(sf[0]),
        .out_valid(ov[0]), .out_ready(rdy[0]), .out_data(od[0]));
    pulse_stream_buffer #(.WIDTH(W), .KIND(BUF_HALF), .DEPTH(4), .CIRCULAR(1'b0)) uut_half (
        .clk(clk), .clear(clear), .in_strobe(strobe[1]), .in_data(din), .slot_free(sf[1]),
        .out_valid(ov[1]), .out_ready(rdy[1]), .out_data(od[1]));
    pulse_stream_buffer #(.WIDTH(W), .KIND(BUF_SKID), .DEPTH(4), .CIRCULAR(1'b0)) uut_skid (
        .clk(clk), .clear(clear), .in_strobe(strobe[2]), .in_data(din), .slot_free(sf[2]),
        .out_valid(ov[2]), .out_ready(rdy[2]), .out_data(od[2]));
    pulse_stream_buffer #(.WIDTH(W), .KIND(BUF_FIFO), .DEPTH(4), .CIRCULAR(1'b1)) uut_circ (
        .clk(clk), .clear(clear), .in_strobe(strobe[3]), .in_data(din), .slot_free(sf[3]),
        .out_valid(ov[3]), .out_ready(rdy[3]), .out_data(od[3]));

    task automatic fail(input int i, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        errors++;
        $display("FAIL [%s] inst %0d %s: got %h expected %h", tag, i, what, got, exp);
    endtask

    task automatic check_all();
        for (int i = 0; i < N; i++) begin
            bit ev;
            ev = (mq[i].size() != 0);
            checks++;
            if (ov[i] !== ev) fail(i, "out_valid (R3 R4 R5 R11)", W'(ov[i]), W'(ev));
            if (ev) begin
                checks++;
                if (od[i] !== mq[i][0]) fail(i, "out_data (R2 R12)", od[i], mq[i][0]);
            end
            checks++;
            if (sf[i] !== exp_sf[i])
                fail(i, circs[i] ? "slot_free R7" : "slot_free R6", W'(sf[i]), W'(exp_sf[i]));
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < N; i++) begin
            if (clear) begin
                mq[i].delete();
                exp_sf[i] = 1'b0;
            end else begin
                bit popd, fulld;
                fulld = (mq[i].size() == caps[i]);
                popd  = (mq[i].size() != 0) && rdy[i];
                if (popd) void'(mq[i].pop_front());
                if (circs[i]) begin
                    if (strobe[i]) begin
                        if (mq[i].size() == caps[i]) void'(mq[i].pop_front());
                        mq[i].push_back(din);
                    end
                    exp_sf[i] = strobe[i];
                end else begin
                    if (strobe[i] && (!fulld || popd)) mq[i].push_back(din);
                    exp_sf[i] = popd;
                end
            end
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL [watchdog] run incomplete: got timeout expected finish");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) tick();
        clear = 1'b0;

        // R3 R4 R5 R10 R11: strobe into stalled storage, new word each cycle (R2)
        tag = "R3 R4 R5 R10 R11 R2";
        strobe = '1; rdy = '0;
        for (int k = 0; k < 7; k++) begin
            din = W'(8'h10 + k);
            tick();
        end

        // R8: stalled consumer, data must hold
        tag = "R8";
        strobe = '0; din = 8'hEE;
        repeat (3) tick();

        // R6 R12: drain in order
        tag = "R6 R12";
        rdy = '1;
        repeat (6) tick();

        // R9: fill, then strobe and handshake together while full
        tag = "R9";
        rdy = '0; strobe = '1;
        for (int k = 0; k < 4; k++) begin din = W'(8'h40 + k); tick(); end
        rdy = '1;
        for (int k = 0; k < 4; k++) begin din = W'(8'h50 + k); tick(); end
        strobe = '0;
        repeat (6) tick();

        // R1: clear with handshakes and strobes in flight
        tag = "R1";
        strobe = '1; rdy = '0;
        repeat (3) begin din = din + 1'b1; tick(); end
        rdy = '1; clear = 1'b1;
        tick();
        clear = 1'b0; strobe = '0; rdy = '0;
        tick();

        // R10 R7: circular overwrite under long stalls
        tag = "R10 R7";
        for (int k = 0; k < 40; k++) begin
            strobe = '1;
            rdy = (k % 9 == 8) ? '1 : '0;
            din = W'(8'h80 + k);
            tick();
        end
        strobe = '0; rdy = '1;
        repeat (6) tick();

        // R2 R12 R6 R7: irregular traffic
        tag = "R2 R12 R6 R7";
        for (int k = 0; k < 500; k++) begin
            for (int i = 0; i < N; i++) begin
                strobe[i] = ($urandom % 2) == 0;
                rdy[i]    = ($urandom % 3) != 0;
            end
            din = W'($urandom);
            tick();
        end
        strobe = '0; rdy = '1;
        repeat (6) tick();

        finish_run();
    end
endmodule